// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter with Cascade

This block is a small reversible binary counter that has two count inputs. One input steps the count up and the other steps it down. A rising edge on the up input adds one while the down input rests high. A rising edge on the down input subtracts one while the up input rests high. A free-running system clock samples both count inputs through two-flop synchronizers, and the block compares each synchronized sample with the previous one to find rising edges. All count bits update on the same system clock edge.

An active-low load copies a parallel data word into the count, and this overrides the count inputs. An active-high clear sets the count to zero, and this overrides load and counting. Two active-low outputs, carry and borrow, mark the top and bottom of the range. Each is gated by the low phase of the matching count input. A wider counter is built by wiring a stage's carry to the next stage's up input and its borrow to the next stage's down input. When the pulse on a carry or borrow output ends, its rising edge steps the next stage.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `q` is 0 and both `carry_n` and `borrow_n` are 1. The synchronizers start in the idle-high state.
- R2: A rising edge on `cnt_up`, with `cnt_dn` held high, increases `q` by one.
- R3: A rising edge on `cnt_dn`, with `cnt_up` held high, decreases `q` by one.
- R4: The count holds in two cases. The first is a rising edge on one count input while the other input is low. The second is rising edges on both inputs in the same sampled cycle.
- R5: While `load_n` is low and `clear` is low, `q` takes `din` on every clock. Count edges that arrive during this time have no effect.
- R6: While `clear` is high, `q` becomes 0 on every clock. Clear overrides `load_n` and both count inputs.
- R7: `carry_n` is 0 exactly when `q` is all ones and the synchronized `cnt_up` is low. Otherwise it is 1.
- R8: `borrow_n` is 0 exactly when `q` is zero and the synchronized `cnt_dn` is low. Otherwise it is 1.
- R9: An up step from all ones gives 0. A down step from 0 gives all ones.
- R10: Two stages chained through carry to up and borrow to down act as one 8-bit counter. The high stage steps when the low stage wraps. The high stage's `carry_n` goes low only when the full 8-bit value is 255 and the count input is low.
- R11: After `cnt_up` rises, `q` is still unchanged following the second system clock edge and has changed following the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up | input | 1 | Up count input; a rising edge increments the count |
| cnt_dn | input | 1 | Down count input; a rising edge decrements the count |
| load_n | input | 1 | Active-low parallel preset |
| clear | input | 1 | Active-high clear to zero |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry: count at maximum and `cnt_up` low |
| borrow_n | output | 1 | Active-low borrow: count at zero and `cnt_dn` low |

## Verification
The hardest case to reach from the ports is a clear that arrives while the low stage holds its maximum with `cnt_up` low. In that state the low stage's carry is already active. Clearing the low stage releases its carry, and that release is a rising edge on the high stage's up input. The edge reaches the high stage while clear is still high, so clear must absorb it. The bench sets up this case by chaining two instances, presetting 0x4F, lowering the up input and then raising clear for several cycles. It then expects 0x00, and 0x01 after the next up pulse. The bench also produces simultaneous edges on both count inputs, and an up edge while the down input is low followed by a down edge while the up input is high.

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] up_sh, dn_sh;
  logic up_prev, dn_prev;
  logic up_s, dn_s, up_rise, dn_rise, step_up, step_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_sh   <= '1;
      dn_sh   <= '1;
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_sh   <= {up_sh[SYNC_STAGES-2:0], cnt_up};
      dn_sh   <= {dn_sh[SYNC_STAGES-2:0], cnt_dn};
      up_prev <= up_s;
      dn_prev <= dn_s;
    end
  end

  assign up_s    = up_sh[SYNC_STAGES-1];
  assign dn_s    = dn_sh[SYNC_STAGES-1];
  assign up_rise = up_s & ~up_prev;
  assign dn_rise = dn_s & ~dn_prev;
  assign step_up = up_rise & dn_s & ~dn_rise;
  assign step_dn = dn_rise & up_s & ~up_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (clear)   q <= '0;
    else if (!load_n) q <= din;
    else if (step_up) q <= q + 1'b1;
    else if (step_dn) q <= q - 1'b1;
  end

  assign carry_n  = ~((q == CNT_MAX) & ~up_s);
  assign borrow_n = ~((q == '0) & ~dn_s);

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == '0));
  p_load_din_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_n) |=> (q == $past(din)));
  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && up_rise && dn_s && !dn_rise) |=> (q == WIDTH'($past(q) + 1)));
  p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && dn_rise && up_s && !up_rise) |=> (q == WIDTH'($past(q) - 1)));
  p_hold_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && up_rise && dn_rise) |=> $stable(q));
  p_hold_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && up_rise && !dn_s) |=> $stable(q));
  p_carry_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q == CNT_MAX));
  p_borrow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == '0));

endmodule

// File: tb/test_updn_cascade_counter.sv
module test_updn_cascade_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_up = 1'b1, cnt_dn = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [7:0] din8 = '0;
  logic [3:0] q_lo, q_hi;
  logic carry_lo, borrow_lo, carry_hi, borrow_hi;
  int vectors = 0, miscompares = 0, model = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_cascade_counter i_updn_cascade_counter (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .load_n(load_n), .clear(clear), .din(din8[3:0]), .q(q_lo),
    .carry_n(carry_lo), .borrow_n(borrow_lo));

  updn_cascade_counter i_updn_cascade_counter_hi (
    .clk(clk), .rst_n(rst_n), .cnt_up(carry_lo), .cnt_dn(borrow_lo),
    .load_n(load_n), .clear(clear), .din(din8[7:4]), .q(q_hi),
    .carry_n(carry_hi), .borrow_n(borrow_hi));

  function automatic int q16();
    return int'({q_hi, q_lo});
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(int v);
    din8 = v[7:0]; load_n = 1'b0; wait_n(2);
    load_n = 1'b1; wait_n(2);
    model = v & 255;
  endtask

  task automatic pulse_up(string tag);
    cnt_up = 1'b0; wait_n(4);
    chk({tag, " R7 carry_lo"}, int'(carry_lo), ((model % 16) == 15) ? 0 : 1);
    chk({tag, " R10 carry_hi"}, int'(carry_hi), (model == 255) ? 0 : 1);
    cnt_up = 1'b1; wait_n(8);
    model = (model + 1) & 255;
    chk(tag, q16(), model);
  endtask

  task automatic pulse_dn(string tag);
    cnt_dn = 1'b0; wait_n(4);
    chk({tag, " R8 borrow_lo"}, int'(borrow_lo), ((model % 16) == 0) ? 0 : 1);
    chk({tag, " R10 borrow_hi"}, int'(borrow_hi), (model == 0) ? 0 : 1);
    cnt_dn = 1'b1; wait_n(8);
    model = (model - 1) & 255;
    chk(tag, q16(), model);
  endtask

  task automatic t_reset();
    chk("R1 q", q16(), 0);
    chk("R1 carry", int'(carry_lo), 1);
    chk("R1 borrow", int'(borrow_lo), 1);
  endtask

  task automatic t_count_up();
    do_load(8'h0D);
    for (int i = 0; i < 5; i++) pulse_up("R2 R10 up");
  endtask

  task automatic t_count_dn();
    do_load(8'h12);
    for (int i = 0; i < 4; i++) pulse_dn("R3 R10 down");
  endtask

  task automatic t_wrap();
    do_load(8'hFE);
    pulse_up("R9 up");
    pulse_up("R9 R10 wrap up");
    pulse_dn("R9 R10 wrap down");
  endtask

  task automatic t_latency();
    do_load(8'h20);
    cnt_up = 1'b0; wait_n(4);
    cnt_up = 1'b1;
    wait_n(2);
    chk("R11 two edges", q16(), 8'h20);
    wait_n(1);
    chk("R11 three edges", q16(), 8'h21);
    wait_n(6);
  endtask

  task automatic t_ignore();
    do_load(8'h35);
    cnt_up = 1'b0; wait_n(3);
    cnt_dn = 1'b0; wait_n(4);
    cnt_up = 1'b1; wait_n(8);
    chk("R4 up while down low", q16(), 8'h35);
    cnt_dn = 1'b1; wait_n(8);
    chk("R3 down while up high", q16(), 8'h34);
    cnt_up = 1'b0; cnt_dn = 1'b0; wait_n(4);
    cnt_up = 1'b1; cnt_dn = 1'b1; wait_n(8);
    chk("R4 both rise", q16(), 8'h34);
  endtask

  task automatic t_load_over_count();
    do_load(8'h51);
    cnt_up = 1'b0; wait_n(4);
    din8 = 8'h77; load_n = 1'b0;
    cnt_up = 1'b1; wait_n(8);
    load_n = 1'b1; wait_n(4);
    chk("R5 load over count", q16(), 8'h77);
    model = 8'h77;
  endtask

  task automatic t_clear_over_load();
    din8 = 8'hAA; load_n = 1'b0; clear = 1'b1; wait_n(3);
    chk("R6 clear over load", q16(), 0);
    load_n = 1'b1; clear = 1'b0; wait_n(2);
    chk("R6 stays zero", q16(), 0);
    model = 0;
  endtask

  task automatic t_clear_mid_carry();
    do_load(8'h4F);
    cnt_up = 1'b0; wait_n(4);
    chk("R7 carry at max", int'(carry_lo), 0);
    clear = 1'b1; wait_n(8);
    clear = 1'b0; wait_n(2);
    chk("R6 clear absorbs cascade edge", q16(), 0);
    cnt_up = 1'b1; wait_n(8);
    chk("R6 count after clear", q16(), 1);
    model = 1;
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_count_up();
    t_count_dn();
    t_wrap();
    t_latency();
    t_ignore();
    t_load_over_count();
    t_clear_over_load();
    t_clear_mid_carry();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule